// File: doc/BRIEF.md
# Stereo Audio Transmit Buffer Status Controller

This block holds a pair of 24-bit sample registers, one for channel A and one for channel B. The processor writes these registers between frames. On each frame-start strobe from the serializer, the block copies the pair into its transmit stage. It then tells the processor, through a status word and a level interrupt, that fresh samples are needed.

The processor can fall behind. If the sample pair has not been fully refilled when the next frame starts, the block does not send stale or half-updated data. It sends the previous pair again and raises an underrun flag. The underrun flag has no interrupt line of its own. While it is set, the vector-select output tells the interrupt controller to use the underrun vector instead of the normal one.

Two control bits are sent in bits 29 and 30 of each channel B subframe: the user-data bit and the channel-status bit. The processor writes them into a control register. The transmit stage picks them up at the next frame start. No reset changes them.

Top module: `tx_buf_status`

## Requirements
- R1: The 24-bit status word has the empty flag at bit 0 and the underrun flag at bit 2. All other bits always read 0.
- R2: A frame start with the empty flag clear copies both holding registers into the transmit outputs. In every frame start that is not blocked by a reset or stop, the empty flag is 1 in the following cycle.
- R3: After an upload, the empty flag clears only once both channel A and channel B have been written. It goes low in the cycle after the second of the two writes.
- R4: A software reset pulse, the stop request, and hardware reset each clear the empty flag, the underrun flag and both written flags.
- R5: A frame start while the empty flag is 1 sets the underrun flag. The transmit outputs keep the previous sample pair.
- R6: The interrupt request is a level signal: 1 exactly while the empty flag and the interrupt enable are both 1.
- R7: The vector-select output is 1 while the underrun flag is set. When the empty flag is clear, a set underrun flag by itself leaves the interrupt request at 0.
- R8: Values written to the user-data and channel-status control bits appear on the channel B bit-29 and bit-30 outputs in the cycle after the next frame start. They do not appear earlier.
- R9: No reset (hardware, software or stop) changes the control bits or the channel B bit outputs.
- R10: While the stop request is high, frame starts are ignored. The transmit outputs hold and the flags stay clear.
- R11: The underrun flag clears at the next frame start that finds the empty flag clear.
- R12: Hardware reset sets the holding registers and the transmit outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| stop_req | input | 1 | Stop state: clears flags and blocks uploads while high |
| irq_en | input | 1 | Interrupt enable |
| hold_a_we | input | 1 | Write strobe for the channel A holding register |
| hold_a_din | input | DW | Channel A write data |
| hold_b_we | input | 1 | Write strobe for the channel B holding register |
| hold_b_din | input | DW | Channel B write data |
| ctl_we | input | 1 | Write strobe for the channel B control bits |
| ctl_ub_din | input | 1 | User-data bit to be sent |
| ctl_cs_din | input | 1 | Channel-status bit to be sent |
| frame_start | input | 1 | Frame-start strobe from the serializer |
| tx_a | output | DW | Channel A sample in the transmit stage |
| tx_b | output | DW | Channel B sample in the transmit stage |
| tx_b_ub | output | 1 | Bit 29 of the channel B subframe |
| tx_b_cs | output | 1 | Bit 30 of the channel B subframe |
| status | output | 24 | Status word |
| irq | output | 1 | Level interrupt request |
| irq_vec_sel | output | 1 | 1 selects the underrun vector |

## Verification
Some behaviours are checked by the assertions on every clock cycle:
- the empty flag is set after every unblocked frame start;
- the underrun flag is set, and the sample pair is held, when a frame starts while the flag is already set;
- both flags clear after a software reset or stop;
- the stop request freezes the transmit stage;
- the underrun flag clears after a successful upload;
- the channel B bits follow the control register at the upload.

Other behaviours can only be shown by the bench's directed scenarios:
- the empty flag clearing only after both channels are written, and not after just one;
- the vector select while an interrupt is pending;
- the control bits surviving every kind of reset;
- the data values after a hardware reset.

// File: rtl/tx_buf_status.sv
module tx_buf_status #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          stop_req,
  input  logic          irq_en,
  input  logic          hold_a_we,
  input  logic [DW-1:0] hold_a_din,
  input  logic          hold_b_we,
  input  logic [DW-1:0] hold_b_din,
  input  logic          ctl_we,
  input  logic          ctl_ub_din,
  input  logic          ctl_cs_din,
  input  logic          frame_start,
  output logic [DW-1:0] tx_a,
  output logic [DW-1:0] tx_b,
  output logic          tx_b_ub,
  output logic          tx_b_cs,
  output logic [23:0]   status,
  output logic          irq,
  output logic          irq_vec_sel
);

  logic [DW-1:0] hold_a, hold_b;
  logic got_a, got_b, empty, underrun;
  logic ctl_ub, ctl_cs;

  wire clr    = soft_rst | stop_req;
  wire upload = frame_start & ~clr;
  wire got_a_nx = (got_a & ~upload) | hold_a_we;
  wire got_b_nx = (got_b & ~upload) | hold_b_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a   <= '0;
      hold_b   <= '0;
      tx_a     <= '0;
      tx_b     <= '0;
      got_a    <= 1'b0;
      got_b    <= 1'b0;
      empty    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (hold_a_we) hold_a <= hold_a_din;
      if (hold_b_we) hold_b <= hold_b_din;
      if (clr) begin
        got_a    <= 1'b0;
        got_b    <= 1'b0;
        empty    <= 1'b0;
        underrun <= 1'b0;
      end else begin
        got_a <= got_a_nx;
        got_b <= got_b_nx;
        if (upload) begin
          empty    <= 1'b1;
          underrun <= empty;
          if (!empty) begin
            tx_a <= hold_a;
            tx_b <= hold_b;
          end
        end else if (got_a_nx && got_b_nx) begin
          empty <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl_we) begin
      ctl_ub <= ctl_ub_din;
      ctl_cs <= ctl_cs_din;
    end
    if (upload) begin
      tx_b_ub <= ctl_ub;
      tx_b_cs <= ctl_cs;
    end
  end

  assign status      = {21'd0, underrun, 1'b0, empty};
  assign irq         = empty & irq_en;
  assign irq_vec_sel = underrun;

  p_empty_after_upload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !soft_rst && !stop_req) |=> status[0]);

  p_underrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !soft_rst && !stop_req && status[0]) |=> status[2]);

  p_repeat_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && status[0]) |=> ($stable(tx_a) && $stable(tx_b)));

  p_clear_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst || stop_req) |=> (status[0] == 1'b0 && status[2] == 1'b0));

  p_stop_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> ($stable(tx_a) && $stable(tx_b)));

  p_underrun_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !soft_rst && !stop_req && !status[0]) |=> !irq_vec_sel);

  p_chb_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !soft_rst && !stop_req) |=> (tx_b_ub == $past(ctl_ub) && tx_b_cs == $past(ctl_cs)));

endmodule

// File: tb/tb_tx_buf_status.sv
module tb_tx_buf_status;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, stop_req = 1'b0, irq_en = 1'b0;
  logic hold_a_we = 1'b0, hold_b_we = 1'b0, ctl_we = 1'b0;
  logic [DW-1:0] hold_a_din = '0, hold_b_din = '0;
  logic ctl_ub_din = 1'b0, ctl_cs_din = 1'b0, frame_start = 1'b0;
  logic [DW-1:0] tx_a, tx_b;
  logic tx_b_ub, tx_b_cs, irq, irq_vec_sel;
  logic [23:0] status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tx_buf_status #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_req(stop_req),
    .irq_en(irq_en), .hold_a_we(hold_a_we), .hold_a_din(hold_a_din),
    .hold_b_we(hold_b_we), .hold_b_din(hold_b_din), .ctl_we(ctl_we),
    .ctl_ub_din(ctl_ub_din), .ctl_cs_din(ctl_cs_din), .frame_start(frame_start),
    .tx_a(tx_a), .tx_b(tx_b), .tx_b_ub(tx_b_ub), .tx_b_cs(tx_b_cs),
    .status(status), .irq(irq), .irq_vec_sel(irq_vec_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_a(input logic [DW-1:0] v);
    hold_a_din = v; hold_a_we = 1'b1;
    @(negedge clk); hold_a_we = 1'b0;
  endtask

  task automatic write_b(input logic [DW-1:0] v);
    hold_b_din = v; hold_b_we = 1'b1;
    @(negedge clk); hold_b_we = 1'b0;
  endtask

  task automatic write_ctl(input logic ub, input logic cs);
    ctl_ub_din = ub; ctl_cs_din = cs; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 status after reset", {8'd0, status}, 32'h0);
    check("R6 irq after reset", {31'd0, irq}, 32'h0);
    check("R12 tx_a after reset", {8'd0, tx_a}, 32'h0);
  endtask

  task automatic t_normal_upload();
    write_ctl(1'b1, 1'b0);
    frame();
    check("R2 empty set after upload", {8'd0, status}, 32'h1);
    write_a(24'h111111);
    check("R3 empty held after A only", {8'd0, status}, 32'h1);
    write_b(24'h222222);
    check("R3 empty cleared after A and B", {8'd0, status}, 32'h0);
    frame();
    check("R2 tx_a loaded", {8'd0, tx_a}, 32'h111111);
    check("R2 tx_b loaded", {8'd0, tx_b}, 32'h222222);
    check("R1 status empty only", {8'd0, status}, 32'h1);
    check("R8 ub sent", {31'd0, tx_b_ub}, 32'h1);
    check("R8 cs sent", {31'd0, tx_b_cs}, 32'h0);
  endtask

  task automatic t_underrun();
    write_a(24'h333333);
    frame();
    check("R5 underrun flag", {8'd0, status}, 32'h5);
    check("R5 tx_a repeated", {8'd0, tx_a}, 32'h111111);
    check("R5 tx_b repeated", {8'd0, tx_b}, 32'h222222);
    irq_en = 1'b1;
    @(negedge clk);
    check("R6 irq with enable", {31'd0, irq}, 32'h1);
    check("R7 underrun vector", {31'd0, irq_vec_sel}, 32'h1);
    irq_en = 1'b0;
    @(negedge clk);
    check("R6 irq masked", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_recover();
    write_a(24'h444444);
    write_b(24'h555555);
    check("R3 empty clear, underrun kept", {8'd0, status}, 32'h4);
    irq_en = 1'b1;
    @(negedge clk);
    check("R7 underrun alone no irq", {31'd0, irq}, 32'h0);
    frame();
    check("R11 underrun cleared", {8'd0, status}, 32'h1);
    check("R2 tx_a new", {8'd0, tx_a}, 32'h444444);
    check("R7 normal vector", {31'd0, irq_vec_sel}, 32'h0);
    check("R6 irq raised", {31'd0, irq}, 32'h1);
    irq_en = 1'b0;
  endtask

  task automatic t_chb_latency();
    write_ctl(1'b0, 1'b1);
    check("R8 ub not before frame", {31'd0, tx_b_ub}, 32'h1);
    frame();
    check("R8 ub after frame", {31'd0, tx_b_ub}, 32'h0);
    check("R8 cs after frame", {31'd0, tx_b_cs}, 32'h1);
  endtask

  task automatic t_resets();
    soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R4 soft reset clears", {8'd0, status}, 32'h0);
    check("R9 ub kept over soft reset", {31'd0, tx_b_ub}, 32'h0);
    frame();
    check("R9 ctl kept over soft reset", {30'd0, tx_b_cs, tx_b_ub}, 32'h2);
    stop_req = 1'b1;
    @(negedge clk);
    check("R4 stop clears", {8'd0, status}, 32'h0);
    write_a(24'h666666);
    write_b(24'h777777);
    frame();
    check("R10 frame ignored in stop", {8'd0, tx_a}, 32'h444444);
    check("R10 flags clear in stop", {8'd0, status}, 32'h0);
    stop_req = 1'b0;
    write_ctl(1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R4 hw reset clears", {8'd0, status}, 32'h0);
    check("R12 tx_b zeroed", {8'd0, tx_b}, 32'h0);
    check("R9 ub kept over hw reset", {31'd0, tx_b_ub}, 32'h0);
    frame();
    check("R9 ctl kept over hw reset", {30'd0, tx_b_cs, tx_b_ub}, 32'h3);
    check("R12 holding zeroed", {8'd0, tx_a}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_normal_upload();
    t_underrun();
    t_recover();
    t_chb_latency();
    t_resets();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #160000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule